// File: doc/BRIEF.md
# Locked IDE Timing Register Window

This block sits behind the eight byte addresses of an IDE command-block I/O window. While locked, every access is forwarded unchanged to a task-file interface, and the task-file read data is returned. A fixed three-access key opens the window: two 16-bit reads at offset 1, then a byte write of 0x03 at offset 2. While the window is open, the same offsets reach a small file of timing configuration registers and the task file sees nothing. A byte write of 0x83 at offset 2 closes the window again.

There are two timing sets, one for each attached device, and each set holds a read-cycle byte and a write-cycle byte. Bit 0 of the miscellaneous register chooses which set the timing offsets reach. Software writes a device's timing bytes and then the miscellaneous register, which carries the shared address-setup value in its upper nibble. Writing 0x85 to the control register commits the shadow values. After the commit, timing set 0 drives device 0's outputs and timing set 1 drives device 1's outputs. Each timing byte is exported as two nibbles: the upper nibble counts active cycles and the lower nibble counts recovery cycles. A read-only strap bit reports the bus clock. It can also be read in locked mode right after the two key reads.

Top module: `ide_timing_window`

## Requirements
- R1: After reset the window is locked and the key detector is idle. Every shadow and active timing byte is 0xFF, so every exported nibble is 0xF. The address-setup output, the control register and the miscellaneous register are 0.
- R2: The window opens (`window_open` = 1 in the cycle after the access) only after this exact sequence: a 16-bit read at offset 1, a second 16-bit read at offset 1, then a byte write of 0x03 at offset 2.
- R3: Any access that does not continue the key sequence sends the detector back to idle. A third 16-bit read at offset 1 also sends it to idle. A byte read at offset 1 does not count as a key read, and a 16-bit write of 0x03 does not count as the final key write. After a break, the sequence must start again from its first read.
- R4: While locked, each access appears on the task-file port in the same cycle, with the same write flag, width flag, offset and write data, and `acc_rdata` equals `tf_rdata`. The one exception is the strap read of R8.
- R5: While open, `tf_valid` stays 0. Offset 0 reaches the read-cycle timing byte, offset 1 the write-cycle timing byte, offset 3 the control register, offset 5 the strap register and offset 6 the miscellaneous register. Reads return the addressed value in the same cycle.
- R6: Writes and reads at offsets 0 and 1 go to the timing set chosen by bit 0 of the miscellaneous register (0 selects set 0, 1 selects set 1). The other set is left unchanged.
- R7: The control register reads back its last written value. A write of 0x85 to it loads both shadow sets into the active outputs and loads the upper nibble of the miscellaneous register into `addr_setup`; the new values appear in the next cycle. Until such a write, the active outputs hold their values. Set s drives `set_*_act[4s+3:4s]` from bits 7:4 of its byte and `set_*_rec[4s+3:4s]` from bits 3:0.
- R8: The strap register reads as `{7'b0, bus_clk_25}` (0 means 33 MHz, 1 means 25 MHz) and ignores writes. While locked, a byte read at offset 5 that directly follows the two key reads returns the same value and is not forwarded to the task file.
- R9: While open, offsets 2, 4 and 7 read as 0x00. Writes to them are ignored, except for the relock value at offset 2.
- R10: While open, a byte write of 0x83 at offset 2 locks the window from the next cycle and restores task-file forwarding. Shadow registers and active outputs keep their values, and active outputs do not change while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Window access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_addr | input | 3 | Window offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the access cycle |
| tf_valid | output | 1 | Forwarded task-file access strobe |
| tf_write | output | 1 | Forwarded write flag |
| tf_wide | output | 1 | Forwarded width flag |
| tf_addr | output | 3 | Forwarded offset |
| tf_wdata | output | 8 | Forwarded write data |
| tf_rdata | input | 8 | Task-file read data |
| bus_clk_25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| window_open | output | 1 | 1 while configuration registers are mapped |
| set_rd_act | output | 8 | Read active nibble per timing set |
| set_rd_rec | output | 8 | Read recovery nibble per timing set |
| set_wr_act | output | 8 | Write active nibble per timing set |
| set_wr_rec | output | 8 | Write recovery nibble per timing set |
| addr_setup | output | 4 | Committed shared address-setup value |

## Verification
Read data and task-file forwarding are combinational, so they are due in the cycle of the access itself. The bench drives each access on the falling edge and samples `acc_rdata` and the task-file port 1 ns later, before the next rising edge. Register writes, lock changes and committed timing outputs appear one cycle after the access. The bench checks these on the following falling edge, after the rising edge that captured them. Checks on the key sequence and on the strap read look at `window_open` and at the forwarding of the access that follows, so every claim that an access was ignored is checked at the ports.

// File: rtl/ide_win_pkg.sv
`timescale 1ns/1ps
package ide_win_pkg;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_ONE   = 2'd1,
        LK_TWO   = 2'd2,
        WIN_OPEN = 2'd3
    } lock_st_e;

    localparam logic [2:0] OFS_RDT   = 3'd0;
    localparam logic [2:0] OFS_WRT   = 3'd1;
    localparam logic [2:0] OFS_KEY   = 3'd2;
    localparam logic [2:0] OFS_CTL   = 3'd3;
    localparam logic [2:0] OFS_STRAP = 3'd5;
    localparam logic [2:0] OFS_MISC  = 3'd6;

    localparam logic [7:0] KEY_OPEN   = 8'h03;
    localparam logic [7:0] KEY_CLOSE  = 8'h83;
    localparam logic [7:0] CTL_COMMIT = 8'h85;

endpackage

// File: rtl/ide_win_unlock.sv
`timescale 1ns/1ps
module ide_win_unlock
    import ide_win_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_wide,
    input  logic [2:0] acc_addr,
    input  logic [7:0] acc_wdata,
    output logic       win_open,
    output logic       strap_peek
);

    typedef struct packed {
        lock_st_e st;
    } det_t;

    det_t det_d, det_q;

    logic key_rd, key_wr_open, key_wr_close;

    always_comb begin
        key_rd       = !acc_write && acc_wide && (acc_addr == OFS_WRT);
        key_wr_open  = acc_write && !acc_wide && (acc_addr == OFS_KEY) && (acc_wdata == KEY_OPEN);
        key_wr_close = acc_write && !acc_wide && (acc_addr == OFS_KEY) && (acc_wdata == KEY_CLOSE);
        det_d = det_q;
        if (acc_valid) begin
            unique case (det_q.st)
                LK_IDLE:  det_d.st = key_rd ? LK_ONE : LK_IDLE;
                LK_ONE:   det_d.st = key_rd ? LK_TWO : LK_IDLE;
                LK_TWO:   det_d.st = key_wr_open ? WIN_OPEN : LK_IDLE;
                WIN_OPEN: det_d.st = key_wr_close ? LK_IDLE : WIN_OPEN;
                default:  det_d.st = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q.st <= LK_IDLE;
        else        det_q    <= det_d;
    end

    assign win_open   = (det_q.st == WIN_OPEN);
    assign strap_peek = (det_q.st == LK_TWO);

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !$past(win_open)) |-> $past(acc_valid && acc_write && !acc_wide &&
            acc_addr == OFS_KEY && acc_wdata == KEY_OPEN)); // R2

    AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win_open && acc_valid && acc_write && !acc_wide &&
            acc_addr == OFS_KEY && acc_wdata == KEY_CLOSE) |-> !win_open); // R10

endmodule

// File: rtl/ide_win_regs.sv
`timescale 1ns/1ps
module ide_win_regs
    import ide_win_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NSETS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            acc_addr,
    input  logic [DW-1:0]         acc_wdata,
    input  logic                  strap_in,
    output logic [DW-1:0]         reg_rdata,
    output logic [NSETS*DW-1:0]   act_rd,
    output logic [NSETS*DW-1:0]   act_wr,
    output logic [DW/2-1:0]       addr_setup
);

    localparam int SELW = (NSETS > 1) ? $clog2(NSETS) : 1;
    localparam int HW   = DW / 2;

    typedef struct packed {
        logic [NSETS-1:0][DW-1:0] sh_rd;
        logic [NSETS-1:0][DW-1:0] sh_wr;
        logic [NSETS-1:0][DW-1:0] ac_rd;
        logic [NSETS-1:0][DW-1:0] ac_wr;
        logic [DW-1:0]            ctl;
        logic [DW-1:0]            misc;
        logic [HW-1:0]            aset;
    } regs_t;

    regs_t r_d, r_q;
    logic [SELW-1:0] sel;

    always_comb begin
        sel = r_q.misc[SELW-1:0];
        r_d = r_q;
        if (wr_en) begin
            case (acc_addr)
                OFS_RDT:  r_d.sh_rd[sel] = acc_wdata;
                OFS_WRT:  r_d.sh_wr[sel] = acc_wdata;
                OFS_CTL: begin
                    r_d.ctl = acc_wdata;
                    if (acc_wdata == CTL_COMMIT) begin
                        r_d.ac_rd = r_q.sh_rd;
                        r_d.ac_wr = r_q.sh_wr;
                        r_d.aset  = r_q.misc[DW-1:DW-HW];
                    end
                end
                OFS_MISC: r_d.misc = acc_wdata;
                default:  r_d = r_q;
            endcase
        end
    end

    always_comb begin
        case (acc_addr)
            OFS_RDT:   reg_rdata = r_q.sh_rd[sel];
            OFS_WRT:   reg_rdata = r_q.sh_wr[sel];
            OFS_CTL:   reg_rdata = r_q.ctl;
            OFS_STRAP: reg_rdata = {{(DW-1){1'b0}}, strap_in};
            OFS_MISC:  reg_rdata = r_q.misc;
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sh_rd <= '1;
            r_q.sh_wr <= '1;
            r_q.ac_rd <= '1;
            r_q.ac_wr <= '1;
            r_q.ctl   <= '0;
            r_q.misc  <= '0;
            r_q.aset  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign act_rd     = r_q.ac_rd;
    assign act_wr     = r_q.ac_wr;
    assign addr_setup = r_q.aset;

    AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && acc_addr == OFS_CTL && acc_wdata == CTL_COMMIT) |->
            ($stable(act_rd) && $stable(act_wr) && $stable(addr_setup))); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(r_q.sh_rd) && $stable(r_q.sh_wr))); // R6

endmodule

// File: rtl/ide_timing_window.sv
`timescale 1ns/1ps
module ide_timing_window
    import ide_win_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NSETS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic                    acc_wide,
    input  logic [2:0]              acc_addr,
    input  logic [DW-1:0]           acc_wdata,
    output logic [DW-1:0]           acc_rdata,
    output logic                    tf_valid,
    output logic                    tf_write,
    output logic                    tf_wide,
    output logic [2:0]              tf_addr,
    output logic [DW-1:0]           tf_wdata,
    input  logic [DW-1:0]           tf_rdata,
    input  logic                    bus_clk_25,
    output logic                    window_open,
    output logic [NSETS*DW/2-1:0]   set_rd_act,
    output logic [NSETS*DW/2-1:0]   set_rd_rec,
    output logic [NSETS*DW/2-1:0]   set_wr_act,
    output logic [NSETS*DW/2-1:0]   set_wr_rec,
    output logic [DW/2-1:0]         addr_setup
);

    localparam int HW = DW / 2;

    logic                  strap_peek, strap_hit, reg_wr;
    logic [DW-1:0]         reg_rdata;
    logic [NSETS*DW-1:0]   act_rd, act_wr;

    ide_win_unlock u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_wide   (acc_wide),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata[7:0]),
        .win_open   (window_open),
        .strap_peek (strap_peek)
    );

    always_comb begin
        strap_hit = acc_valid && !acc_write && !acc_wide &&
                    (acc_addr == OFS_STRAP) && strap_peek;
        reg_wr    = acc_valid && acc_write && window_open;
        tf_valid  = acc_valid && !window_open && !strap_hit;
        tf_write  = acc_write;
        tf_wide   = acc_wide;
        tf_addr   = acc_addr;
        tf_wdata  = acc_wdata;
        acc_rdata = (window_open || strap_hit) ? reg_rdata : tf_rdata;
    end

    ide_win_regs #(.DW(DW), .NSETS(NSETS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .strap_in   (bus_clk_25),
        .reg_rdata  (reg_rdata),
        .act_rd     (act_rd),
        .act_wr     (act_wr),
        .addr_setup (addr_setup)
    );

    for (genvar s = 0; s < NSETS; s++) begin : g_split
        assign set_rd_act[s*HW +: HW] = act_rd[s*DW+HW +: HW];
        assign set_rd_rec[s*HW +: HW] = act_rd[s*DW +: HW];
        assign set_wr_act[s*HW +: HW] = act_wr[s*DW+HW +: HW];
        assign set_wr_rec[s*HW +: HW] = act_wr[s*DW +: HW];
    end

    AST_TF_SILENT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        window_open |-> !tf_valid); // R5

    AST_LOCKED_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(window_open) |-> ($stable(set_rd_act) && $stable(set_rd_rec) &&
            $stable(set_wr_act) && $stable(set_wr_rec) && $stable(addr_setup))); // R10

endmodule

// File: tb/ide_timing_window_bench.sv
`timescale 1ns/1ps
module ide_timing_window_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
    logic [2:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       tf_valid, tf_write, tf_wide;
    logic [2:0] tf_addr;
    logic [7:0] tf_wdata;
    logic [7:0] tf_rdata = 8'hA5;
    logic       bus_clk_25 = 1'b1;
    logic       window_open;
    logic [7:0] set_rd_act, set_rd_rec, set_wr_act, set_wr_rec;
    logic [3:0] addr_setup;

    int  nvec = 0, nbad = 0;
    bit  done = 1'b0;
    logic [7:0] s_rd;
    logic       s_tfv;

    always #2.5 clk = ~clk;

    ide_timing_window u_ide_timing_window (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .tf_valid(tf_valid), .tf_write(tf_write),
        .tf_wide(tf_wide), .tf_addr(tf_addr), .tf_wdata(tf_wdata),
        .tf_rdata(tf_rdata), .bus_clk_25(bus_clk_25), .window_open(window_open),
        .set_rd_act(set_rd_act), .set_rd_rec(set_rd_rec), .set_wr_act(set_wr_act),
        .set_wr_rec(set_wr_rec), .addr_setup(addr_setup)
    );

    // {write, wide, addr[2:0], wdata[7:0], check, expected[7:0]}, window open
    localparam int NV = 22;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'hFF},
        {1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 8'hFF},
        {1'b1, 1'b0, 3'd6, 8'h20, 1'b0, 8'h00},
        {1'b1, 1'b0, 3'd0, 8'h59, 1'b0, 8'h00},
        {1'b1, 1'b0, 3'd1, 8'h46, 1'b0, 8'h00},
        {1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'h59},
        {1'b0, 1'b0, 3'd1, 8'h00, 1'b1, 8'h46},
        {1'b1, 1'b0, 3'd6, 8'h31, 1'b0, 8'h00},
        {1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'hFF},
        {1'b1, 1'b0, 3'd0, 8'h32, 1'b0, 8'h00},
        {1'b1, 1'b0, 3'd1, 8'h20, 1'b0, 8'h00},
        {1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'h32},
        {1'b0, 1'b0, 3'd6, 8'h00, 1'b1, 8'h31},
        {1'b1, 1'b0, 3'd6, 8'h30, 1'b0, 8'h00},
        {1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 8'h59},
        {1'b0, 1'b0, 3'd2, 8'h00, 1'b1, 8'h00},
        {1'b1, 1'b0, 3'd4, 8'h77, 1'b0, 8'h00},
        {1'b0, 1'b0, 3'd4, 8'h00, 1'b1, 8'h00},
        {1'b1, 1'b0, 3'd2, 8'h12, 1'b0, 8'h00},
        {1'b0, 1'b0, 3'd7, 8'h00, 1'b1, 8'h00},
        {1'b0, 1'b0, 3'd3, 8'h00, 1'b1, 8'h00},
        {1'b1, 1'b0, 3'd5, 8'hFE, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic wd, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_wide = wd; acc_addr = a; acc_wdata = d;
        #1;
        s_rd  = acc_rdata;
        s_tfv = tf_valid;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic settle;
        @(negedge clk);
        #1;
    endtask

    task automatic key_reads;
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
    endtask

    task automatic unlock;
        key_reads();
        acc(1'b1, 1'b0, 3'd2, 8'h03);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nvec++; nbad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 locked", {15'd0, window_open}, 16'd0);
        chk("R1 rd nibbles", {set_rd_act, set_rd_rec}, 16'hFFFF);
        chk("R1 wr nibbles", {set_wr_act, set_wr_rec}, 16'hFFFF);
        chk("R1 addr setup", {12'd0, addr_setup}, 16'd0);

        // R4 locked forwarding
        acc(1'b1, 1'b0, 3'd3, 8'h5C);
        chk("R4 fwd write", {s_tfv, tf_write, tf_wide, tf_addr, tf_wdata}, {1'b1, 1'b1, 1'b0, 3'd3, 8'h5C});
        acc(1'b0, 1'b1, 3'd6, 8'h00);
        chk("R4 fwd read data", {7'd0, s_tfv, s_rd}, {7'd0, 1'b1, 8'hA5});

        // R3 broken key sequences
        acc(1'b0, 1'b1, 3'd1, 8'h00); acc(1'b1, 1'b0, 3'd2, 8'h03);
        settle(); chk("R3 single read", {15'd0, window_open}, 16'd0);
        key_reads(); acc(1'b0, 1'b0, 3'd0, 8'h00); acc(1'b1, 1'b0, 3'd2, 8'h03);
        settle(); chk("R3 foreign access", {15'd0, window_open}, 16'd0);
        acc(1'b0, 1'b1, 3'd1, 8'h00); acc(1'b0, 1'b0, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00); acc(1'b1, 1'b0, 3'd2, 8'h03);
        settle(); chk("R3 byte read at 1", {15'd0, window_open}, 16'd0);
        key_reads(); acc(1'b0, 1'b1, 3'd1, 8'h00); acc(1'b1, 1'b0, 3'd2, 8'h03);
        settle(); chk("R3 third read", {15'd0, window_open}, 16'd0);
        key_reads(); acc(1'b1, 1'b1, 3'd2, 8'h03);
        settle(); chk("R3 wide key write", {15'd0, window_open}, 16'd0);
        acc(1'b1, 1'b0, 3'd2, 8'h03);
        settle(); chk("R3 restart required", {15'd0, window_open}, 16'd0);

        // R8 locked strap peek
        bus_clk_25 = 1'b1;
        key_reads(); acc(1'b0, 1'b0, 3'd5, 8'h00);
        chk("R8 locked strap 25", {7'd0, s_tfv, s_rd}, {7'd0, 1'b0, 8'h01});
        bus_clk_25 = 1'b0;
        key_reads(); acc(1'b0, 1'b0, 3'd5, 8'h00);
        chk("R8 locked strap 33", {7'd0, s_tfv, s_rd}, {7'd0, 1'b0, 8'h00});
        acc(1'b0, 1'b0, 3'd5, 8'h00);
        chk("R8 no preamble fwd", {7'd0, s_tfv, s_rd}, {7'd0, 1'b1, 8'hA5});

        // R2 unlock
        unlock();
        settle(); chk("R2 open", {15'd0, window_open}, 16'd1);

        // vector table: R5 R6 R8 R9
        bus_clk_25 = 1'b1;
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][21], VEC[i][20], VEC[i][19:17], VEC[i][16:9]);
            chk($sformatf("R5 no forwarding vec %0d", i), {15'd0, s_tfv}, 16'd0);
            if (VEC[i][8])
                chk($sformatf("R6 R9 readback vec %0d", i), {8'd0, s_rd}, {8'd0, VEC[i][7:0]});
        end
        acc(1'b0, 1'b0, 3'd5, 8'h00);
        chk("R8 strap ro", {8'd0, s_rd}, 16'h0001);
        settle(); chk("R9 still open", {15'd0, window_open}, 16'd1);

        // R7 commit
        chk("R7 before commit", {set_rd_act, set_rd_rec, addr_setup, 4'd0}, {16'hFFFF, 8'h00} >> 8 << 8 | 16'h0000);
        chk("R7 before commit wr", {set_wr_act, set_wr_rec}, 16'hFFFF);
        acc(1'b1, 1'b0, 3'd3, 8'h85);
        settle();
        chk("R7 rd act", {8'd0, set_rd_act}, 16'h0035);
        chk("R7 rd rec", {8'd0, set_rd_rec}, 16'h0029);
        chk("R7 wr act", {8'd0, set_wr_act}, 16'h0024);
        chk("R7 wr rec", {8'd0, set_wr_rec}, 16'h0006);
        chk("R7 addr setup", {12'd0, addr_setup}, 16'h0003);
        acc(1'b0, 1'b0, 3'd3, 8'h00);
        chk("R7 ctl readback", {8'd0, s_rd}, 16'h0085);
        acc(1'b1, 1'b0, 3'd6, 8'h21);
        acc(1'b1, 1'b0, 3'd0, 8'h99);
        acc(1'b1, 1'b0, 3'd3, 8'h11);
        settle();
        chk("R7 non-commit hold", {set_rd_act, set_rd_rec}, 16'h3529);
        chk("R7 non-commit aset", {12'd0, addr_setup}, 16'h0003);

        // R10 relock
        acc(1'b1, 1'b0, 3'd2, 8'h83);
        settle(); chk("R10 locked", {15'd0, window_open}, 16'd0);
        acc(1'b1, 1'b0, 3'd0, 8'h44);
        chk("R10 forwarding", {7'd0, s_tfv, tf_wdata}, {7'd0, 1'b1, 8'h44});
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        chk("R10 fwd read", {8'd0, s_rd}, 16'h00A5);
        settle(); chk("R10 outputs kept", {set_rd_act, set_rd_rec}, 16'h3529);
        unlock();
        acc(1'b0, 1'b0, 3'd6, 8'h00);
        chk("R10 misc kept", {8'd0, s_rd}, 16'h0021);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        chk("R10 shadow kept", {8'd0, s_rd}, 16'h0099);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule